// File: doc/BRIEF.md
# Codec Serial Link Controller With Control-Register Access

This block is the host-side end of a synchronous serial link to an audio codec. The codec is the timing master: it drives the bit clock and the frame sync. The controller over-samples both with its own system clock. Every frame moves one 16-bit word out of the controller and one 16-bit word into it, most significant bit first. Normal (primary) frames send a DAC sample to the codec and return an ADC sample.

Software-side logic can also ask for one control-register access at a time, either a read or a write. The controller signals the request in the next primary frame. In the 15+1 mode it uses the low bit of the outgoing sample. In the 16-bit mode it uses a separate active-high request pin. The frame that follows is a secondary frame. It carries a direction flag, a 5-bit register address and 8 data bits. When that frame completes, a done pulse is issued, and for a read the returned byte is presented.

Top module: `codec_link_ctrl`

## Requirements
- R1: In 16-bit mode (`mode_16`=1), a primary frame sends `dac_sample` unchanged on `cdc_sdout`, MSB first. It presents all 16 received bits on `adc_sample` with `adc_ms`=0 and pulses `adc_valid`.
- R2: In 15+1 mode (`mode_16`=0), bits 15..1 of a primary outgoing word are `dac_sample[15:1]` and bit 0 is the request flag. Received bit 0 appears on `adc_ms`, and `adc_sample` is the received word with bit 0 forced to 0.
- R3: In 15+1 mode, the outgoing flag bit is 1 only in the first primary frame that starts after a request is accepted. `cdc_req` stays 0.
- R4: In 16-bit mode, bit 0 of the DAC sample is sent unchanged. `cdc_req` goes high at the start of the flagged primary frame and falls at the start of the secondary frame.
- R5: The outgoing secondary word has bits 15..14 = 0, bit 13 = direction (1 read, 0 write), bits 12..8 = address, and bits 7..0 = write data (zero for a read).
- R6: The frame after a flagged primary frame is secondary. It produces no `adc_valid` and no `dac_taken`.
- R7: After a read's secondary frame, `reg_rdata` equals the low 8 bits of the received word and `reg_done` pulses for one cycle.
- R8: After a write's secondary frame, `reg_done` pulses and `reg_rdata` keeps its previous value.
- R9: `reg_ready` falls when a request is accepted and rises again with `reg_done`. A request made while `reg_ready` is 0 is ignored.
- R10: After reset, `cdc_sdout`, `cdc_req`, `reg_done`, `adc_valid` and `reg_rdata` are 0 and `reg_ready` is 1.
- R11: A frame starts at a bit-clock falling edge that finds `cdc_fs` high. The 16 following falling edges sample the input bits, and the output bit changes after each rising edge.
- R12: `dac_taken` pulses once at the start of every primary frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times the bit-clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_16 | input | 1 | 1 = full 16-bit samples, 0 = 15 data bits plus 1 flag bit |
| cdc_sclk | input | 1 | Bit clock from the codec |
| cdc_fs | input | 1 | Frame sync from the codec |
| cdc_sdin | input | 1 | Serial data from the codec |
| cdc_sdout | output | 1 | Serial data to the codec |
| cdc_req | output | 1 | Active-high register-access request pin (16-bit mode) |
| dac_sample | input | 16 | Next sample to send |
| dac_taken | output | 1 | Pulse: `dac_sample` was loaded for a primary frame |
| adc_sample | output | 16 | Last received sample |
| adc_ms | output | 1 | Codec status bit from the last 15+1 sample |
| adc_valid | output | 1 | Pulse: new `adc_sample` |
| reg_req | input | 1 | Request a register access |
| reg_rd | input | 1 | 1 = read, 0 = write |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_ready | output | 1 | No access outstanding |
| reg_done | output | 1 | Pulse: register access completed |
| reg_rdata | output | 8 | Data returned by the last read |

## Verification
The bench builds the controller with the default two-stage input synchronizer and the fixed 16-bit word. It plays the codec with a bit-clock half period of eight system clocks. That spacing gives the synchronizer and the output register enough room for every bit to be sampled cleanly, so one walked table can cover both primary modes with MSB and LSB patterns. A full read and a full write are then run through the request, flagged and secondary frames. A request issued while busy exposes the one-outstanding rule at the ports.

// File: rtl/codec_link_pkg.sv
// Shared constants, access-state type and secondary-word packer for the
// codec serial link controller. Assumes the fixed 16-bit word format.
package codec_link_pkg;

    localparam int WORD_W = 16;
    localparam int ADDR_W = 5;
    localparam int REG_W  = 8;

    // Progress of a single register access through the frame sequence.
    typedef enum logic [1:0] {
        ACC_IDLE,   // nothing outstanding
        ACC_PEND,   // accepted, waiting for the next primary frame
        ACC_FLAG,   // request flagged in the current primary frame
        ACC_SEC     // secondary frame under way
    } acc_state_t;

    // Packs the outgoing control word: zeros, direction, address, data.
    function automatic logic [WORD_W-1:0] pack_ctrl_word(
        input logic              rd,
        input logic [ADDR_W-1:0] addr,
        input logic [REG_W-1:0]  data
    );
        logic [REG_W-1:0] payload;
        payload = rd ? '0 : data;
        return {2'b00, rd, addr, payload};
    endfunction

endpackage

// File: rtl/codec_sync.sv
// Brings the codec's bit clock, frame sync and data into the system clock
// domain through a STAGES-deep register chain and flags bit-clock edges.
// Assumes the bit clock is slower than clk / 4 so no edge is missed.
module codec_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic fs_i,
    input  logic sd_i,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic fs_s,
    output logic sd_s
);
    localparam int LANES = 3;
    localparam int PW    = LANES * STAGES;

    logic [PW-1:0] pipe;
    logic          sclk_prev;
    logic          sclk_now;

    generate
        if (STAGES == 1) begin : g_single
            // Single-stage capture of the three codec lines.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= {sclk_i, fs_i, sd_i};
            end
        end else begin : g_chain
            // Multi-stage chain; newest sample enters at the low lanes.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= {pipe[PW-LANES-1:0], sclk_i, fs_i, sd_i};
            end
        end
    endgenerate

    assign sclk_now = pipe[PW-1];
    assign fs_s     = pipe[PW-2];
    assign sd_s     = pipe[PW-3];

    // Remember the previous synchronized bit clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk_now;
    end

    assign sclk_rise = sclk_now & ~sclk_prev;
    assign sclk_fall = ~sclk_now & sclk_prev;

endmodule

// File: rtl/codec_shifter.sv
// Serializes one outgoing word and deserializes one incoming word per frame.
// Frame start: a bit-clock fall seeing frame sync high while idle. Input bits
// are taken on the next W falls, output bits change after each rise.
// Assumes the tx word is valid in the cycle frame_start is high.
module codec_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk_rise,
    input  logic         sclk_fall,
    input  logic         fs_s,
    input  logic         sd_s,
    input  logic [W-1:0] tx_word,
    output logic         frame_start,
    output logic         word_done,
    output logic [W-1:0] rx_word,
    output logic         sdout
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] rx_left;
    logic [CW-1:0] tx_left;
    logic [W-1:0]  rx_sr;
    logic [W-1:0]  tx_sr;

    assign frame_start = sclk_fall && fs_s && (rx_left == '0);
    assign rx_word     = rx_sr;

    // Shift engine: load on frame start, receive on falls, send on rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_left   <= '0;
            tx_left   <= '0;
            rx_sr     <= '0;
            tx_sr     <= '0;
            sdout     <= 1'b0;
            word_done <= 1'b0;
        end else begin
            word_done <= 1'b0;
            if (frame_start) begin
                rx_left <= CW'(W);
                tx_left <= CW'(W);
                tx_sr   <= tx_word;
            end else if (sclk_fall && rx_left != '0) begin
                rx_sr   <= {rx_sr[W-2:0], sd_s};
                rx_left <= rx_left - CW'(1);
                if (rx_left == CW'(1)) word_done <= 1'b1;
            end else if (sclk_rise) begin
                if (tx_left != '0) begin
                    sdout   <= tx_sr[W-1];
                    tx_sr   <= {tx_sr[W-2:0], 1'b0};
                    tx_left <= tx_left - CW'(1);
                end else begin
                    sdout   <= 1'b0;
                end
            end
        end
    end

    AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(sclk_rise && sclk_fall)) else $error("edges overlap"); // R11
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rx_left <= CW'(W)) else $error("bit count overflow"); // R11
    AST_START_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> !word_done) else $error("start during done"); // R11

endmodule

// File: rtl/codec_frame_ctl.sv
// Chooses the kind of each frame, builds the outgoing word and decodes the
// incoming one. It owns the single-outstanding register-access sequence:
// accept, flag in a primary frame, run the secondary frame, report done.
// Assumes frame_start and word_done never coincide.
module codec_frame_ctl
    import codec_link_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_16,
    input  logic              frame_start,
    input  logic              word_done,
    input  logic [WORD_W-1:0] rx_word,
    output logic [WORD_W-1:0] tx_word,
    input  logic [WORD_W-1:0] dac_sample,
    output logic              dac_taken,
    output logic [WORD_W-1:0] adc_sample,
    output logic              adc_ms,
    output logic              adc_valid,
    input  logic              reg_req,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic              reg_ready,
    output logic              reg_done,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              req_pin
);
    acc_state_t        st;
    logic              cur_sec;
    logic              rd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [REG_W-1:0]  wdata_q;
    logic              accept;

    assign reg_ready = (st == ACC_IDLE);
    assign accept    = reg_req && reg_ready;
    assign req_pin   = mode_16 && (st == ACC_FLAG);

    // Outgoing word for a frame starting now, chosen from the access state.
    always_comb begin
        if (st == ACC_FLAG)  tx_word = pack_ctrl_word(rd_q, addr_q, wdata_q);
        else if (mode_16)    tx_word = dac_sample;
        else                 tx_word = {dac_sample[WORD_W-1:1], st == ACC_PEND};
    end

    // Access sequencing, frame bookkeeping and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ACC_IDLE;
            cur_sec    <= 1'b0;
            rd_q       <= 1'b0;
            addr_q     <= '0;
            wdata_q    <= '0;
            dac_taken  <= 1'b0;
            adc_valid  <= 1'b0;
            adc_sample <= '0;
            adc_ms     <= 1'b0;
            reg_done   <= 1'b0;
            reg_rdata  <= '0;
        end else begin
            dac_taken <= 1'b0;
            adc_valid <= 1'b0;
            reg_done  <= 1'b0;
            if (frame_start) begin
                if (st == ACC_FLAG) begin
                    st      <= ACC_SEC;
                    cur_sec <= 1'b1;
                end else begin
                    cur_sec   <= 1'b0;
                    dac_taken <= 1'b1;
                    if (st == ACC_PEND) st <= ACC_FLAG;
                end
            end
            if (accept) begin
                st      <= ACC_PEND;
                rd_q    <= reg_rd;
                addr_q  <= reg_addr;
                wdata_q <= reg_wdata;
            end
            if (word_done) begin
                if (cur_sec) begin
                    cur_sec  <= 1'b0;
                    st       <= ACC_IDLE;
                    reg_done <= 1'b1;
                    if (rd_q) reg_rdata <= rx_word[REG_W-1:0];
                end else begin
                    adc_valid <= 1'b1;
                    if (mode_16) begin
                        adc_sample <= rx_word;
                        adc_ms     <= 1'b0;
                    end else begin
                        adc_sample <= {rx_word[WORD_W-1:1], 1'b0};
                        adc_ms     <= rx_word[0];
                    end
                end
            end
        end
    end

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_ready) |=> !reg_ready) else $error("second access"); // R9
    AST_READY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_done |-> reg_ready) else $error("done while busy"); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_done |=> !reg_done) else $error("done too long"); // R7
    AST_SEC_NO_ADC: assert property (@(posedge clk) disable iff (!rst_n)
        reg_done |-> !adc_valid) else $error("sample from control frame"); // R6
    AST_PIN_FALLS_AT_SEC: assert property (@(posedge clk) disable iff (!rst_n)
        (req_pin && frame_start) |=> !req_pin) else $error("pin stuck"); // R4

endmodule

// File: rtl/codec_link_ctrl.sv
// Top of the host-side codec serial link controller: synchronizer, shifter
// and frame/register-access control. Assumes the codec masters both the
// bit clock and the frame sync and that clk runs well above the bit rate.
module codec_link_ctrl
    import codec_link_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_16,
    input  logic                cdc_sclk,
    input  logic                cdc_fs,
    input  logic                cdc_sdin,
    output logic                cdc_sdout,
    output logic                cdc_req,
    input  logic [WORD_W-1:0]   dac_sample,
    output logic                dac_taken,
    output logic [WORD_W-1:0]   adc_sample,
    output logic                adc_ms,
    output logic                adc_valid,
    input  logic                reg_req,
    input  logic                reg_rd,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic                reg_ready,
    output logic                reg_done,
    output logic [REG_W-1:0]    reg_rdata
);
    logic              sclk_rise;
    logic              sclk_fall;
    logic              fs_s;
    logic              sd_s;
    logic              frame_start;
    logic              word_done;
    logic [WORD_W-1:0] rx_word;
    logic [WORD_W-1:0] tx_word;

    codec_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (cdc_sclk),
        .fs_i      (cdc_fs),
        .sd_i      (cdc_sdin),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .fs_s      (fs_s),
        .sd_s      (sd_s)
    );

    codec_shifter #(.W(WORD_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_rise   (sclk_rise),
        .sclk_fall   (sclk_fall),
        .fs_s        (fs_s),
        .sd_s        (sd_s),
        .tx_word     (tx_word),
        .frame_start (frame_start),
        .word_done   (word_done),
        .rx_word     (rx_word),
        .sdout       (cdc_sdout)
    );

    codec_frame_ctl u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_16     (mode_16),
        .frame_start (frame_start),
        .word_done   (word_done),
        .rx_word     (rx_word),
        .tx_word     (tx_word),
        .dac_sample  (dac_sample),
        .dac_taken   (dac_taken),
        .adc_sample  (adc_sample),
        .adc_ms      (adc_ms),
        .adc_valid   (adc_valid),
        .reg_req     (reg_req),
        .reg_rd      (reg_rd),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_ready   (reg_ready),
        .reg_done    (reg_done),
        .reg_rdata   (reg_rdata),
        .req_pin     (cdc_req)
    );

endmodule

// File: tb/tb_codec_link_ctrl.sv
// Bench: plays the codec (bit clock, frame sync, serial data) and the host.
module tb_codec_link_ctrl;
    localparam int HP = 8;  // bit-clock half period in system clocks

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_16 = 1'b1;
    logic        cdc_sclk = 1'b0, cdc_fs = 1'b0, cdc_sdin = 1'b0;
    logic        cdc_sdout, cdc_req;
    logic [15:0] dac_sample = '0;
    logic        dac_taken;
    logic [15:0] adc_sample;
    logic        adc_ms, adc_valid;
    logic        reg_req = 1'b0, reg_rd = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_ready, reg_done;
    logic [7:0]  reg_rdata;

    int total = 0, bad = 0;
    int n_adc = 0, n_dac = 0, n_done = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    codec_link_ctrl dut (
        .clk(clk), .rst_n(rst_n), .mode_16(mode_16),
        .cdc_sclk(cdc_sclk), .cdc_fs(cdc_fs), .cdc_sdin(cdc_sdin),
        .cdc_sdout(cdc_sdout), .cdc_req(cdc_req),
        .dac_sample(dac_sample), .dac_taken(dac_taken),
        .adc_sample(adc_sample), .adc_ms(adc_ms), .adc_valid(adc_valid),
        .reg_req(reg_req), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_ready(reg_ready), .reg_done(reg_done),
        .reg_rdata(reg_rdata)
    );

    // Pulse counters, sampled away from the active edge.
    always @(negedge clk) begin
        if (adc_valid) n_adc++;
        if (dac_taken) n_dac++;
        if (reg_done)  n_done++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One frame as the codec: fs at a rise, start fall, 16 data bits.
    task automatic run_frame(input logic [15:0] to_ctl, output logic [15:0] from_ctl);
        cdc_sclk = 1'b1; cdc_fs = 1'b1; wclk(HP);
        cdc_sclk = 1'b0; wclk(HP);
        for (int i = 15; i >= 0; i--) begin
            cdc_sclk = 1'b1; cdc_fs = 1'b0; cdc_sdin = to_ctl[i]; wclk(HP);
            from_ctl[i] = cdc_sdout;
            cdc_sclk = 1'b0; wclk(HP);
        end
        for (int k = 0; k < 2; k++) begin
            cdc_sclk = 1'b1; cdc_sdin = 1'b0; wclk(HP);
            cdc_sclk = 1'b0; wclk(HP);
        end
    endtask

    task automatic request(input logic rd, input logic [4:0] a, input logic [7:0] d);
        reg_rd = rd; reg_addr = a; reg_wdata = d; reg_req = 1'b1;
        wclk(1);
        reg_req = 1'b0;
        wclk(1);
    endtask

    // {mode_16, dac word, word the codec returns}
    localparam logic [32:0] VEC [6] = '{
        {1'b1, 16'hA5C3, 16'h8001},
        {1'b1, 16'h0001, 16'hFFFF},
        {1'b1, 16'h8000, 16'h1234},
        {1'b0, 16'h7FFF, 16'h0001},
        {1'b0, 16'hC3A4, 16'hFFFE},
        {1'b0, 16'h8001, 16'h5AA5}
    };

    initial begin
        logic [15:0] got;
        logic [15:0] exp_tx, exp_adc;
        logic        exp_ms;
        int a0, d0, dn0;

        wclk(4);
        // R10: reset state
        chk(cdc_sdout == 1'b0, "R10 sdout", cdc_sdout, 0);
        chk(cdc_req == 1'b0, "R10 req pin", cdc_req, 0);
        chk(reg_ready == 1'b1, "R10 ready", reg_ready, 1);
        chk(reg_done == 1'b0 && adc_valid == 1'b0, "R10 pulses", {reg_done, adc_valid}, 0);
        chk(reg_rdata == 8'h00, "R10 rdata", reg_rdata, 0);
        rst_n = 1'b1;
        wclk(4);

        // R1 R2 R11 R12: primary frames from the table
        foreach (VEC[i]) begin
            mode_16 = VEC[i][32];
            dac_sample = VEC[i][31:16];
            a0 = n_adc; d0 = n_dac;
            run_frame(VEC[i][15:0], got);
            if (mode_16) begin
                exp_tx = VEC[i][31:16]; exp_adc = VEC[i][15:0]; exp_ms = 1'b0;
                chk(got == exp_tx, "R1 R11 tx word 16", got, exp_tx);
                chk(adc_sample == exp_adc && adc_ms == exp_ms, "R1 adc 16", adc_sample, exp_adc);
            end else begin
                exp_tx = {VEC[i][31:17], 1'b0}; exp_adc = {VEC[i][15:1], 1'b0}; exp_ms = VEC[i][0];
                chk(got == exp_tx, "R2 R11 tx word 15+1", got, exp_tx);
                chk(adc_sample == exp_adc, "R2 adc 15+1", adc_sample, exp_adc);
                chk(adc_ms == exp_ms, "R2 status bit", adc_ms, exp_ms);
            end
            chk(n_adc == a0 + 1, "R1 adc_valid count", n_adc - a0, 1);
            chk(n_dac == d0 + 1, "R12 dac_taken count", n_dac - d0, 1);
        end

        // R3 R5 R7: read in 15+1 mode
        mode_16 = 1'b0;
        request(1'b1, 5'h13, 8'hEE);
        chk(reg_ready == 1'b0, "R9 busy after accept", reg_ready, 0);
        dac_sample = 16'h1234;
        run_frame(16'h0000, got);
        chk(got == 16'h1235, "R3 flag bit set", got, 16'h1235);
        chk(cdc_req == 1'b0, "R3 pin low in 15+1", cdc_req, 0);
        a0 = n_adc; d0 = n_dac; dn0 = n_done;
        run_frame(16'h3C5A, got);
        chk(got == 16'h3300, "R5 read word", got, 16'h3300);
        chk(reg_rdata == 8'h5A, "R7 read data", reg_rdata, 8'h5A);
        chk(n_done == dn0 + 1, "R7 done pulse", n_done - dn0, 1);
        chk(n_adc == a0 && n_dac == d0, "R6 no sample on control frame", n_adc - a0, 0);
        chk(reg_ready == 1'b1, "R9 ready after done", reg_ready, 1);
        run_frame(16'h0000, got);
        chk(got == 16'h1234, "R3 flag cleared next frame", got, 16'h1234);

        // R4 R5 R8 R9: write in 16-bit mode, busy request ignored
        mode_16 = 1'b1;
        request(1'b0, 5'h0A, 8'hC3);
        request(1'b1, 5'h1F, 8'h11);
        chk(reg_ready == 1'b0, "R9 still busy", reg_ready, 0);
        chk(cdc_req == 1'b0, "R4 pin low before frame", cdc_req, 0);
        dac_sample = 16'h5551;
        run_frame(16'h0000, got);
        chk(got == 16'h5551, "R4 LSB kept in 16", got, 16'h5551);
        chk(cdc_req == 1'b1, "R4 pin high after flagged frame", cdc_req, 1);
        dn0 = n_done; a0 = n_adc;
        run_frame(16'hFFFF, got);
        chk(got == 16'h0AC3, "R5 write word", got, 16'h0AC3);
        chk(cdc_req == 1'b0, "R4 pin low after secondary", cdc_req, 0);
        chk(reg_rdata == 8'h5A, "R8 rdata unchanged", reg_rdata, 8'h5A);
        chk(n_done == dn0 + 1, "R8 done pulse", n_done - dn0, 1);
        chk(n_adc == a0, "R6 no adc on write frame", n_adc - a0, 0);
        run_frame(16'h0000, got);
        chk(got == 16'h5551 && cdc_req == 1'b0, "R9 ignored request not sent", got, 16'h5551);
        chk(reg_ready == 1'b1, "R9 ready at end", reg_ready, 1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hang expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule